// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block collects up to fifteen interrupt lines from neighbouring logic and condenses them into one interrupt request for a processor. Each incoming line is brought into the local clock domain through a short synchronizer chain. It is then classified, per source, as either a level event or a rising-edge event. An event sets a sticky pending bit that stays set until software removes it by writing a one to the matching position of the clear register.

Software reaches the block through a simple synchronous bus with request, write and address signals. Writes complete at the clock edge where the request is captured. Read data appears on `rdata_o` one edge after that same edge. Five word registers are visible: pending status, clear, trigger mode, mask, and the live level of the inputs. A per-source mask and a master enable together decide whether the pending events raise the request line.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: Registers sit at byte offsets 0x00 (pending status), 0x04 (clear), 0x08 (trigger mode), 0x0C (mask), and 0x10 (live level). Bits 31:16 of every register read 0. The clear offset and unmapped offsets read 0. The trigger mode register holds bits 14:0. The mask register holds bits 15:0.
- R3: A source whose trigger mode bit is 0 is level triggered. Its status bit is set on every cycle in which its synchronized input is 1, and it remains 1 after the input falls.
- R4: A source whose trigger mode bit is 1 is edge triggered. Its status bit is set only when the synchronized input goes from 0 to 1. A clear while the input stays high removes the bit for good, and it is set again only by the next rising edge. A pulse one clock long is caught.
- R5: Writing the clear register removes each status bit written as 1. Bits written as 0 are unaffected.
- R6: When a set condition and a clear of the same bit occur in the same cycle, the bit ends up set. A level source that is still high therefore stays pending through a clear.
- R7: Mask bits 14:0 enable their sources. Status bit 15 reads 1 exactly when some source has both a pending bit and a mask bit set.
- R8: Mask bit 15 is the master enable. While it is 0, `irq_o` is 0, and status bit 15 is unaffected by it.
- R9: The live level register returns each input after two synchronizing flops. It is not latched.
- R10: `irq_o` is registered. It rises one clock after the status bit that causes it.
- R11: An input change captured at clock edge k sets status at edge k+2. `irq_o` follows at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 15 | Raw interrupt lines, asynchronous |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address, bits 4:2 select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one edge after the read request is captured |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a new rising edge on an edge-triggered source that lands in the same cycle as a software clear of that bit. It must not be lost. The bench gets there by counting the synchronizer latency exactly. It raises the input at a falling edge, lets two rising edges pass, and then issues the clear write so that the write is captured on the very edge where the set condition is present. A read of the status then shows whether the set won. The bench also pins the synchronizer and request-register latency by sampling `irq_o` after each of the first four edges that follow an input change.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    REG_STAT = 3'd0,
    REG_CLR  = 3'd1,
    REG_TSEL = 3'd2,
    REG_EN   = 3'd3,
    REG_RAW  = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 15,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_trig.sv
module irq_trig #(
  parameter int W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] tsel_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_src
    assign set_o[g] = tsel_i[g] ? (lvl_i[g] & ~prev_q[g]) : lvl_i[g];
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [W-1:0]      set_i,
  input  logic [W-1:0]      lvl_i,
  output logic [W-1:0]      stat_o,
  output logic [W-1:0]      tsel_o,
  output logic [W:0]        en_o,
  output logic [W-1:0]      clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [2:0]        idx;
  logic              wr, rd;
  logic [W-1:0]      stat_q, tsel_q;
  logic [W:0]        en_q;
  logic [DATA_W-1:0] rd_n, rdata_q;
  logic              unused_bits;

  assign idx = addr_i[ADDR_W-1:2];
  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:W+1]};

  assign clr_o = (wr && idx == REG_CLR) ? wdata_i[W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      tsel_q <= '0;
      en_q   <= '0;
    end else begin
      // set wins over a simultaneous clear
      stat_q <= (stat_q & ~clr_o) | set_i;
      if (wr && idx == REG_TSEL) tsel_q <= wdata_i[W-1:0];
      if (wr && idx == REG_EN)   en_q   <= wdata_i[W:0];
    end
  end

  always_comb begin
    rd_n = '0;
    case (idx)
      REG_STAT: begin
        rd_n[W-1:0] = stat_q;
        rd_n[W]     = |(stat_q & en_q[W-1:0]);
      end
      REG_TSEL: rd_n[W-1:0] = tsel_q;
      REG_EN:   rd_n[W:0]   = en_q;
      REG_RAW:  rd_n[W-1:0] = lvl_i;
      default:  rd_n        = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_n;
  end

  assign stat_o  = stat_q;
  assign tsel_o  = tsel_q;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   irq_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int SYNC_STAGES = 2;

  logic [NSRC-1:0] lvl_w, set_w, clr_w, stat_q, tsel_q;
  logic [NSRC:0]   en_q;
  logic            irq_q;

  irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (lvl_w)
  );

  irq_trig #(.W(NSRC)) u_trig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl_w),
    .tsel_i(tsel_q),
    .set_o (set_w)
  );

  irq_regs #(.W(NSRC)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .set_i  (set_w),
    .lvl_i  (lvl_w),
    .stat_o (stat_q),
    .tsel_o (tsel_q),
    .en_o   (en_q),
    .clr_o  (clr_w),
    .rdata_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_q[NSRC] & |(stat_q & en_q[NSRC-1:0]);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int NSRC = 15
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_o,
  input logic [31:0]     rdata_o,
  input logic [NSRC-1:0] stat_q,
  input logic [NSRC:0]   en_q,
  input logic [NSRC-1:0] set_w,
  input logic [NSRC-1:0] clr_w
);
  // R2: upper bits never carry data
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:NSRC+1] == '0);

  // R6: every set condition is visible in status on the next cycle
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(set_w)) == $past(set_w)));

  // R5: a status bit falls only where a clear of 1 was written
  a_r5_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(clr_w)) == '0));

  // R8: no request without the master enable
  a_r8_global_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q[NSRC] |=> !irq_o);

  // R7: a request needs an enabled pending source one cycle earlier
  a_r7_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(stat_q & en_q[NSRC-1:0])));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .irq_o  (irq_o),
  .rdata_o(rdata_o),
  .stat_q (stat_q),
  .en_q   (en_q),
  .set_w  (set_w),
  .clr_w  (clr_w)
);

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;
  localparam logic [4:0] A_STAT = 5'h00, A_CLR = 5'h04, A_TSEL = 5'h08,
                         A_EN = 5'h0C, A_RAW = 5'h10, A_BAD = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] irq = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;

  int checks = 0;
  int failures = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  irq_status_ctrl uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .irq_i  (irq),
    .req_i  (req),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: one read result appears per captured read request
  always @(posedge clk) rd_seen <= req && !we && rst_n;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rdata === e, t, rdata, e);
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk);
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    check(irq_out === e, t, {31'd0, irq_out}, {31'd0, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    bus_read(A_STAT, 32'h0, "R1 status reset");
    bus_read(A_TSEL, 32'h0, "R1 tsel reset");
    bus_read(A_EN,   32'h0, "R1 mask reset");
    bus_read(A_RAW,  32'h0, "R1 raw reset");
    // R2 widths and reserved bits
    bus_write(A_TSEL, 32'hFFFF_FFFF);
    bus_read(A_TSEL, 32'h0000_7FFF, "R2 tsel width");
    bus_write(A_EN, 32'hFFFF_FFFF);
    bus_read(A_EN, 32'h0000_FFFF, "R2 mask width");
    bus_read(A_CLR, 32'h0, "R2 clear reads zero");
    bus_read(A_BAD, 32'h0, "R2 unmapped reads zero");
    bus_write(A_TSEL, 32'h0);
    bus_write(A_EN, 32'h0000_8002);
    // R11/R10 latency on bit 1
    @(negedge clk); irq[1] = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); chk_irq(1'b0, $sformatf("R11 irq low after edge %0d", k));
    end
    @(negedge clk); chk_irq(1'b1, "R10 irq after edge 4");
    // R3 latched after fall, R9 live level
    irq[1] = 1'b0;
    wait_cyc(4);
    bus_read(A_STAT, 32'h0000_8002, "R3 level latched after fall");
    bus_read(A_RAW, 32'h0, "R9 raw follows low input");
    bus_write(A_CLR, 32'h0);
    bus_read(A_STAT, 32'h0000_8002, "R5 write zero no effect");
    bus_write(A_CLR, 32'h2);
    bus_read(A_STAT, 32'h0, "R5 clear bit 1");
    chk_irq(1'b0, "R5 irq drops after clear");
    // R6 level source re-asserts through clear
    bus_write(A_EN, 32'h0000_8001);
    irq[0] = 1'b1;
    wait_cyc(4);
    bus_read(A_RAW, 32'h0000_0001, "R9 raw shows high input");
    bus_write(A_CLR, 32'h1);
    bus_read(A_STAT, 32'h0000_8001, "R6 level stays pending");
    irq[0] = 1'b0;
    wait_cyc(4);
    bus_write(A_CLR, 32'h1);
    bus_read(A_STAT, 32'h0, "R3 clear after level falls");
    // R4 edge mode on bit 2
    bus_write(A_TSEL, 32'h4);
    bus_write(A_EN, 32'h0000_8004);
    irq[2] = 1'b1;
    wait_cyc(5);
    bus_read(A_STAT, 32'h0000_8004, "R4 edge sets");
    bus_write(A_CLR, 32'h4);
    wait_cyc(3);
    bus_read(A_STAT, 32'h0, "R4 clear sticks while high");
    irq[2] = 1'b0;
    wait_cyc(4);
    @(negedge clk); irq[2] = 1'b1;
    @(negedge clk); irq[2] = 1'b0;
    wait_cyc(5);
    bus_read(A_STAT, 32'h0000_8004, "R4 one cycle pulse caught");
    bus_write(A_CLR, 32'h4);
    // R7 per-source mask on bit 3
    bus_write(A_TSEL, 32'h0);
    bus_write(A_EN, 32'h0000_8000);
    irq[3] = 1'b1;
    wait_cyc(5);
    bus_read(A_STAT, 32'h0000_0008, "R7 masked no summary");
    chk_irq(1'b0, "R7 masked no irq");
    bus_write(A_EN, 32'h0000_8008);
    wait_cyc(2);
    chk_irq(1'b1, "R7 unmasked irq");
    // R8 master enable
    bus_write(A_EN, 32'h0000_0008);
    wait_cyc(2);
    chk_irq(1'b0, "R8 master off");
    bus_read(A_STAT, 32'h0000_8008, "R8 summary independent of master");
    irq[3] = 1'b0;
    wait_cyc(4);
    bus_write(A_CLR, 32'h8);
    // R6 edge and clear in the same cycle on bit 4
    bus_write(A_TSEL, 32'h10);
    bus_write(A_EN, 32'h0000_8010);
    @(negedge clk); irq[4] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    bus_write(A_CLR, 32'h10);
    bus_read(A_STAT, 32'h0000_8010, "R6 set beats same-cycle clear");
    bus_write(A_CLR, 32'h10);
    bus_read(A_STAT, 32'h0, "R4 no new edge after clear");
    irq[4] = 1'b0;
    // R7 mixed sources
    bus_write(A_TSEL, 32'h0);
    bus_write(A_EN, 32'h0000_8020);
    irq[5] = 1'b1; irq[6] = 1'b1;
    wait_cyc(5);
    bus_read(A_STAT, 32'h0000_8060, "R7 two pending one enabled");
    chk_irq(1'b1, "R7 irq from enabled source");

    wait_cyc(3);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule